// File: doc/BRIEF.md
# Sub-word memory lane access unit

This block is a small row-organised memory with a front end that serves byte, halfword, word and doubleword accesses. A byte address is split into a row index and a byte offset inside the row. The request size is checked for natural alignment, and a misaligned request is refused. A load picks out the addressed lane and returns it right-justified and zero-extended. A store replaces only the addressed lane and keeps the rest of the row, as a read-modify-write within one cycle. Each access can optionally byte-reverse the value over the access width. On a load the reversal follows lane extraction. On a store it comes before lane insertion.

The row width is a parameter. Data storage typically uses 8-byte rows and instruction storage 4-byte rows. A request is presented for one cycle with `req_valid`. The response comes on the next cycle. A small state machine records what kind of response is due. `ST_IDLE` is the state after a store, or when no request arrived, and it presents nothing. `ST_LOAD` follows an accepted load and presents `rsp_valid`, the data and the written flag. `ST_FAULT` follows a misaligned request and presents `rsp_err`. Every state moves on each cycle. With a misaligned request it moves to `ST_FAULT`. With an aligned load it moves to `ST_LOAD`. With an aligned store, or no request, it moves to `ST_IDLE`.

Top module: `lane_mem`

## Requirements
- R1: The byte offset is the address ANDed with (row bytes − 1), and the row index is the address shifted right by log2(row bytes). Byte k of a row occupies bits 8k+7..8k of the row.
- R2: A request whose offset ANDed with (access bytes − 1) is non-zero raises `rsp_err` for exactly one cycle, on the cycle after the request. `rsp_valid` stays low and `rsp_rdata` is zero in that cycle.
- R3: `req_size` encodes the access size as log2 of the byte count (0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes). A size wider than the row is treated as misaligned.
- R4: An aligned load raises `rsp_valid` on the next cycle. Its data is the addressed lane shifted down by offset×8 and zero-extended above the access width.
- R5: A store narrower than the row changes only the addressed lane and leaves every other byte of the row as it was.
- R6: A store of the full row width writes the supplied value as the whole row.
- R7: With `req_swap` set, a load returns the extracted lane with its bytes reversed over the access width.
- R8: With `req_swap` set, a store reverses the bytes of the write value over the access width before inserting them into the lane.
- R9: A row never stored to since reset reads as zero with `rsp_written` low. After an aligned store to a row, loads from that row report `rsp_written` high.
- R10: A misaligned store leaves memory unchanged.
- R11: After reset, `rsp_valid` and `rsp_err` are low and every row reads as zero.
- R12: An aligned store raises neither `rsp_valid` nor `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address (row index and offset) |
| req_size | input | 2 | log2 of the access size in bytes |
| req_we | input | 1 | 1 = store, 0 = load |
| req_swap | input | 1 | Byte-reverse over the access width |
| req_wdata | input | ROW_BYTES*8 | Store value, right-justified |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | ROW_BYTES*8 | Load data, right-justified |
| rsp_err | output | 1 | Previous request was misaligned |
| rsp_written | output | 1 | Loaded row was stored to since reset |

## Verification
On every cycle, the assertions check the response rules. An error response carries no data and no valid strobe. A valid strobe always follows a load request. An aligned store produces no response. A misaligned store leaves its row untouched. A completed store marks its row as written. The lane contents cannot be checked that way, so the bench scenarios carry them. These cover offset-dependent extraction, preservation of neighbouring bytes, both byte-reversal orders, full-row writes and the oversize rule on a 4-byte-row instance. The bench compares each result against its own byte-level memory model.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;

    function automatic logic [3:0] size_to_bytes(input logic [1:0] size);
        return 4'd1 << size;
    endfunction

endpackage

// File: rtl/lane_geom.sv
module lane_geom
    import lane_mem_pkg::*;
#(
    parameter  int ROW_BYTES = 8,
    parameter  int ROWS      = 16,
    localparam int OFF_W     = $clog2(ROW_BYTES),
    localparam int IDX_W     = $clog2(ROWS),
    localparam int ADDR_W    = OFF_W + IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  row_idx,
    output logic [OFF_W-1:0]  byte_off,
    output logic [3:0]        nbytes,
    output logic              misaligned
);

    logic [OFF_W-1:0] align_mask;

    always_comb begin
        row_idx    = addr[ADDR_W-1:OFF_W];
        byte_off   = addr[OFF_W-1:0];
        nbytes     = size_to_bytes(size);
        align_mask = OFF_W'(nbytes - 4'd1);
        misaligned = (int'(nbytes) > ROW_BYTES) || ((byte_off & align_mask) != '0);
    end

endmodule

// File: rtl/lane_swap.sv
module lane_swap #(
    parameter  int ROW_BYTES = 8,
    localparam int ROW_W     = ROW_BYTES * 8
) (
    input  logic [ROW_W-1:0] din,
    input  logic [3:0]       nbytes,
    input  logic             en,
    output logic [ROW_W-1:0] dout
);

    always_comb begin
        dout = din;
        if (en) begin
            dout = '0;
            for (int i = 0; i < ROW_BYTES; i++) begin
                for (int j = 0; j < ROW_BYTES; j++) begin
                    if (i < int'(nbytes) && j == int'(nbytes) - 1 - i)
                        dout[i*8 +: 8] = din[j*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/lane_mem.sv
module lane_mem
    import lane_mem_pkg::*;
#(
    parameter  int ROW_BYTES = 8,
    parameter  int ROWS      = 16,
    localparam int OFF_W     = $clog2(ROW_BYTES),
    localparam int IDX_W     = $clog2(ROWS),
    localparam int ADDR_W    = OFF_W + IDX_W,
    localparam int ROW_W     = ROW_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic              req_swap,
    input  logic [ROW_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [ROW_W-1:0]  rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_written
);

    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;
    logic [3:0]       nb;
    logic             mis;

    lane_geom #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_geom (
        .addr(req_addr), .size(req_size),
        .row_idx(idx), .byte_off(off), .nbytes(nb), .misaligned(mis)
    );

    logic [ROW_W-1:0] mem_q [ROWS];
    logic [ROWS-1:0]  written_q;
    logic [ROW_W-1:0] row_rd, lane_ext, lane_ld, wr_sw, row_new;

    assign row_rd = mem_q[idx];

    // load lane extraction: byte i of the result is byte off+i of the row
    always_comb begin
        lane_ext = '0;
        for (int i = 0; i < ROW_BYTES; i++) begin
            for (int j = 0; j < ROW_BYTES; j++) begin
                if (i < int'(nb) && j == int'(off) + i)
                    lane_ext[i*8 +: 8] = row_rd[j*8 +: 8];
            end
        end
    end

    lane_swap #(.ROW_BYTES(ROW_BYTES)) u_swap_ld (
        .din(lane_ext), .nbytes(nb), .en(req_swap), .dout(lane_ld)
    );

    lane_swap #(.ROW_BYTES(ROW_BYTES)) u_swap_st (
        .din(req_wdata), .nbytes(nb), .en(req_swap), .dout(wr_sw)
    );

    // store merge: lane bytes replaced, others kept
    always_comb begin
        row_new = row_rd;
        for (int j = 0; j < ROW_BYTES; j++) begin
            for (int i = 0; i < ROW_BYTES; i++) begin
                if (i < int'(nb) && j == int'(off) + i)
                    row_new[j*8 +: 8] = wr_sw[i*8 +: 8];
            end
        end
    end

    logic do_store;
    assign do_store = req_valid && req_we && !mis;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
            written_q <= '0;
        end else if (do_store) begin
            mem_q[idx]     <= row_new;
            written_q[idx] <= 1'b1;
        end
    end

    // response state machine
    rsp_state_e       state_q, state_d;
    logic [ROW_W-1:0] rdata_q;
    logic             wflag_q;

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (mis)          state_d = ST_FAULT;
            else if (!req_we) state_d = ST_LOAD;
            else              state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            wflag_q <= 1'b0;
        end else begin
            state_q <= state_d;
            rdata_q <= (state_d == ST_LOAD) ? lane_ld : '0;
            wflag_q <= (state_d == ST_LOAD) ? written_q[idx] : 1'b0;
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_err     = 1'b0;
        rsp_rdata   = '0;
        rsp_written = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                rsp_valid   = 1'b1;
                rsp_rdata   = rdata_q;
                rsp_written = wflag_q;
            end
            ST_FAULT: rsp_err = 1'b1;
            default: ;
        endcase
    end

    assert_err_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!rsp_valid && rsp_rdata == '0));

    assert_valid_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_we));

    assert_store_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && !mis) |=> (!rsp_valid && !rsp_err));

    assert_bad_store_keeps_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && mis) |=> (mem_q[$past(idx)] == $past(row_rd)));

    assert_store_marks_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && !mis) |=> written_q[$past(idx)]);

endmodule

// File: tb/lane_mem_bench.sv
module lane_mem_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RB = 8;
    localparam int NROWS = 16;
    localparam int AW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0, req_we = 1'b0, req_swap = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err, rsp_written;
    logic [63:0]   rsp_rdata;

    lane_mem #(.ROW_BYTES(RB), .ROWS(NROWS)) u_lane_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_we(req_we), .req_swap(req_swap),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rsp_written(rsp_written)
    );

    logic        n_valid = 1'b0;
    logic [3:0]  n_addr = '0;
    logic [1:0]  n_size = '0;
    logic        n_rvalid, n_err, n_written;
    logic [31:0] n_rdata;

    lane_mem #(.ROW_BYTES(4), .ROWS(4)) u_lane_mem_narrow (
        .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_addr(n_addr),
        .req_size(n_size), .req_we(1'b0), .req_swap(1'b0), .req_wdata(32'h0),
        .rsp_valid(n_rvalid), .rsp_rdata(n_rdata), .rsp_err(n_err),
        .rsp_written(n_written)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] bmem [RB*NROWS];
    bit         bwr  [NROWS];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [1:0] sz, input bit we, input bit sw, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_we = we; req_swap = sw; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    function automatic bit is_mis(input logic [AW-1:0] a, input logic [1:0] sz);
        return (int'(a) % (1 << sz)) != 0;
    endfunction

    task automatic do_load(input logic [AW-1:0] a, input logic [1:0] sz, input bit sw, input string tag);
        logic [63:0] e;
        int nb;
        nb = 1 << sz;
        e = '0;
        for (int i = 0; i < nb; i++)
            e[i*8 +: 8] = sw ? bmem[int'(a) + nb - 1 - i] : bmem[int'(a) + i];
        issue(a, sz, 1'b0, sw, 64'h0);
        if (is_mis(a, sz)) begin
            check(rsp_err && !rsp_valid, {tag, " err"}, {62'h0, rsp_err, rsp_valid}, 64'h2);
            check(rsp_rdata == 0, {tag, " zero data"}, rsp_rdata, 64'h0);
        end else begin
            check(rsp_valid && !rsp_err, {tag, " valid"}, {62'h0, rsp_err, rsp_valid}, 64'h1);
            check(rsp_rdata == e, {tag, " data"}, rsp_rdata, e);
            check(rsp_written == bwr[int'(a) / RB], {tag, " written"}, {63'h0, rsp_written}, {63'h0, bwr[int'(a) / RB]});
        end
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [1:0] sz, input bit sw, input logic [63:0] wd, input string tag);
        int nb;
        nb = 1 << sz;
        issue(a, sz, 1'b1, sw, wd);
        if (is_mis(a, sz)) begin
            check(rsp_err, {tag, " store err"}, {63'h0, rsp_err}, 64'h1);
        end else begin
            check(!rsp_valid && !rsp_err, {tag, " store silent R12"}, {62'h0, rsp_err, rsp_valid}, 64'h0);
            for (int i = 0; i < nb; i++)
                bmem[int'(a) + i] = sw ? wd[(nb - 1 - i)*8 +: 8] : wd[i*8 +: 8];
            bwr[int'(a) / RB] = 1'b1;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!rsp_valid && !rsp_err, "R11 reset outputs", {62'h0, rsp_err, rsp_valid}, 64'h0);
        do_load(7'h00, 2'd3, 1'b0, "R11 row0 zero");
        do_load(7'h78, 2'd3, 1'b0, "R9 unwritten last row");
    endtask

    task automatic t_full_row;
        do_store(7'h10, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, "R6");
        do_load(7'h10, 2'd3, 1'b0, "R6 full row");
        do_load(7'h08, 2'd3, 1'b0, "R1 neighbour row untouched");
        do_load(7'h13, 2'd0, 1'b0, "R1 byte offset 3");
        do_load(7'h14, 2'd2, 1'b0, "R4 upper word");
        do_load(7'h12, 2'd1, 1'b0, "R4 halfword off 2");
    endtask

    task automatic t_narrow_stores;
        do_store(7'h20, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 fill");
        do_store(7'h25, 2'd0, 1'b0, 64'h0000_0000_0000_005A, "R5 byte");
        do_load(7'h20, 2'd3, 1'b0, "R5 byte merge");
        do_store(7'h22, 2'd1, 1'b0, 64'h0000_0000_0000_1234, "R5 half");
        do_store(7'h18, 2'd2, 1'b0, 64'h0000_0000_CAFE_F00D, "R5 word");
        do_load(7'h20, 2'd3, 1'b0, "R5 half merge");
        do_load(7'h18, 2'd3, 1'b0, "R5 word into empty row");
        do_load(7'h1C, 2'd2, 1'b0, "R4 upper word zero");
    endtask

    task automatic t_swaps;
        do_load(7'h10, 2'd2, 1'b1, "R7 swapped word");
        do_load(7'h10, 2'd3, 1'b1, "R7 swapped row");
        do_load(7'h16, 2'd1, 1'b1, "R7 swapped half");
        do_store(7'h34, 2'd2, 1'b1, 64'h0000_0000_1122_3344, "R8");
        do_load(7'h30, 2'd3, 1'b0, "R8 swapped store");
        do_store(7'h3A, 2'd1, 1'b1, 64'h0000_0000_0000_BEEF, "R8 half");
        do_load(7'h38, 2'd3, 1'b0, "R8 swapped half store");
    endtask

    task automatic t_misalign;
        do_load(7'h11, 2'd1, 1'b0, "R2 half odd");
        do_load(7'h12, 2'd2, 1'b0, "R2 word off 2");
        do_load(7'h14, 2'd3, 1'b0, "R2 dword off 4");
        @(negedge clk);
        check(!rsp_err, "R2 err one cycle", {63'h0, rsp_err}, 64'h0);
        do_store(7'h41, 2'd1, 1'b0, 64'hDEAD, "R10");
        do_store(7'h24, 2'd3, 1'b0, 64'h0, "R10 dword");
        do_load(7'h20, 2'd3, 1'b0, "R10 row unchanged");
        do_load(7'h40, 2'd3, 1'b0, "R10 R9 row still unwritten");
    endtask

    task automatic t_oversize;
        @(negedge clk);
        n_valid = 1'b1; n_addr = 4'h0; n_size = 2'd3;
        @(negedge clk);
        n_valid = 1'b0;
        check(n_err && !n_rvalid, "R3 oversize on 4-byte row", {62'h0, n_err, n_rvalid}, 64'h2);
        n_valid = 1'b1; n_addr = 4'h4; n_size = 2'd2;
        @(negedge clk);
        n_valid = 1'b0;
        check(n_rvalid && !n_err && n_rdata == 0, "R3 word on 4-byte row", {31'h0, n_err, n_rdata}, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < RB*NROWS; i++) bmem[i] = 8'h00;
        for (int r = 0; r < NROWS; r++) bwr[r] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_full_row;
        t_narrow_stores;
        t_swaps;
        t_misalign;
        t_oversize;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule